// File: doc/BRIEF.md
# Receive Payload Serial Output Interface

This block hands a recovered serial bit stream to local terminal equipment. Each bit arrives with a one-cycle valid strobe on an internal bit-rate clock. A flag comes with each bit and says whether that position carries overhead or payload. The block drives three outputs: registered serial data, an output clock built from a low-then-high pattern inside each bit period, and an overhead indicator.

A single mode input picks between two clocking styles:

- **Continuous mode** (input low, the expected reset setting): the output clock gives a rising edge for every bit. The indicator is high for every bit period that carries overhead.
- **Gapped mode** (input high): the output clock rises only for payload bits. The clock stays low through overhead bit periods while the data line still advances, and the indicator is held low.

The mode is sampled only at a bit boundary (a valid strobe), so a change never produces a runt clock pulse.

Top module: `rpo_serial_out`

## Requirements
- R1: While rst_ni is low, ser_o, clk_o and ohind_o are all 0.
- R2: In the cycle after a strobe (bit_vld_i=1 at a clock edge), ser_o equals the bit_i sampled with that strobe. It holds that value until the cycle after the next strobe.
- R3: In the cycle after every strobe, clk_o is 0 (the bit boundary falls on a low clock phase).
- R4: In continuous mode, clk_o is 1 from HIGH_DLY cycles after the strobe until the next strobe, for payload and overhead bits alike.
- R5: In gapped mode, a payload bit (oh_i=0) gets a clk_o rise HIGH_DLY cycles after its strobe.
- R6: In gapped mode, an overhead bit (oh_i=1) gets no clk_o rise: clk_o stays 0 for its whole bit period, while ser_o still takes the new bit.
- R7: In continuous mode, ohind_o is 1 for the bit period of an overhead bit and 0 for the bit period of a payload bit, starting in the cycle after the strobe.
- R8: In gapped mode, ohind_o is 0 for every bit period.
- R9: gapped_en_i is sampled only with a strobe. A change between strobes leaves clk_o and ohind_o unchanged until the next strobe.
- R10: At most one clk_o rising edge occurs per bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal bit-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gapped_en_i | input | 1 | 1 = gapped payload-only clock, 0 = continuous clock with indicator |
| bit_vld_i | input | 1 | One-cycle strobe marking a new bit |
| bit_i | input | 1 | Recovered serial bit |
| oh_i | input | 1 | 1 when the bit is overhead |
| ser_o | output | 1 | Serial data to local equipment |
| clk_o | output | 1 | Output clock, rising mid-bit |
| ohind_o | output | 1 | Overhead indicator (continuous mode only) |

## Verification
The assertions assume that strobes are at least HIGH_DLY+1 cycles apart. Under that assumption each bit period contains its low phase and the rise point. The assertions also assume the inputs are low while reset is held.

The bench keeps to these assumptions. It issues a strobe every fourth cycle, with HIGH_DLY at 1, and holds every input at zero during reset. It changes gapped_en_i between strobes only in the dedicated mode-change cases.

// File: rtl/rpo_pkg.sv
package rpo_pkg;
  typedef struct packed {
    logic data;
    logic oh;
  } rpo_bit_t;
endpackage

// File: rtl/rpo_data_reg.sv
module rpo_data_reg
  import rpo_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     strobe_i,
  input  logic     gapped_en_i,
  input  rpo_bit_t bit_i,
  output logic     ser_o,
  output logic     ohind_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_o   <= 1'b0;
      ohind_o <= 1'b0;
    end else if (strobe_i) begin
      ser_o   <= bit_i.data;
      ohind_o <= bit_i.oh & ~gapped_en_i;
    end
  end
endmodule

// File: rtl/rpo_clk_gen.sv
module rpo_clk_gen #(
  parameter int unsigned HIGH_DLY = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic gapped_en_i,
  input  logic oh_i,
  output logic clk_o
);
  localparam int unsigned CW = (HIGH_DLY < 2) ? 1 : $clog2(HIGH_DLY + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(HIGH_DLY);

  logic [CW-1:0] cnt_q;
  logic          gate_q;
  logic          clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      gate_q <= 1'b0;
      clk_q  <= 1'b0;
    end else if (strobe_i) begin
      // mode latched only here: bit boundary, clock forced low
      cnt_q  <= CNT_LOAD;
      gate_q <= ~(gapped_en_i & oh_i);
      clk_q  <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1) && gate_q) clk_q <= 1'b1;
    end
  end

  assign clk_o = clk_q;
endmodule

// File: rtl/rpo_serial_out.sv
module rpo_serial_out
  import rpo_pkg::*;
#(
  parameter int unsigned HIGH_DLY = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gapped_en_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic oh_i,
  output logic ser_o,
  output logic clk_o,
  output logic ohind_o
);
  rpo_bit_t in_bit;
  assign in_bit = '{data: bit_i, oh: oh_i};

  rpo_data_reg u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (bit_vld_i),
    .gapped_en_i(gapped_en_i),
    .bit_i      (in_bit),
    .ser_o      (ser_o),
    .ohind_o    (ohind_o)
  );

  rpo_clk_gen #(.HIGH_DLY(HIGH_DLY)) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (bit_vld_i),
    .gapped_en_i(gapped_en_i),
    .oh_i       (oh_i),
    .clk_o      (clk_o)
  );
endmodule

// File: rtl/rpo_serial_out_chk.sv
module rpo_serial_out_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic gapped_en_i,
  input logic bit_vld_i,
  input logic bit_i,
  input logic oh_i,
  input logic ser_o,
  input logic clk_o,
  input logic ohind_o
);
  logic suppress_q, rose_seen_q, bit_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      suppress_q  <= 1'b0;
      rose_seen_q <= 1'b0;
      bit_seen_q  <= 1'b0;
    end else if (bit_vld_i) begin
      suppress_q  <= gapped_en_i & oh_i;
      rose_seen_q <= 1'b0;
      bit_seen_q  <= 1'b1;
    end else if (clk_o) begin
      rose_seen_q <= 1'b1;
    end
  end

  // R1
  always_comb if (!rst_ni) reset_outs_chk: assert (!ser_o && !clk_o && !ohind_o);

  // R2
  data_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i |=> ser_o == $past(bit_i));

  // R2
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> $stable(ser_o));

  // R3
  boundary_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i |=> !clk_o);

  // R6
  gap_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suppress_q |-> !clk_o);

  // R8
  gap_ind_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i && gapped_en_i |=> !ohind_o);

  // R7
  cont_ind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i && !gapped_en_i |=> ohind_o == $past(oh_i));

  // R9
  ind_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> $stable(ohind_o));

  // R10
  one_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> !rose_seen_q);

  // R4
  rise_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i && bit_seen_q && !suppress_q |-> rose_seen_q || clk_o);
endmodule

bind rpo_serial_out rpo_serial_out_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gapped_en_i(gapped_en_i),
  .bit_vld_i  (bit_vld_i),
  .bit_i      (bit_i),
  .oh_i       (oh_i),
  .ser_o      (ser_o),
  .clk_o      (clk_o),
  .ohind_o    (ohind_o)
);

// File: tb/rpo_serial_out_tb.sv
module rpo_serial_out_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HIGH_DLY   = 1;
  localparam int SPACING    = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic gapped_en_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, oh_i = 1'b0;
  logic ser_o, clk_o, ohind_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rpo_serial_out #(.HIGH_DLY(HIGH_DLY)) u_dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one bit period; optional mid-bit mode flip
  task automatic send_bit(input logic g, input logic oh, input logic b, input logic flip);
    logic exp_clk;
    exp_clk = !(g && oh);
    gapped_en_i = g; oh_i = oh; bit_i = b; bit_vld_i = 1'b1;
    @(negedge clk_i);
    bit_vld_i = 1'b0; oh_i = ~oh; bit_i = ~b;
    chk("R2 load", ser_o, b);
    chk("R3 low at boundary", clk_o, 1'b0);
    chk(g ? "R8 ind low" : "R7 ind", ohind_o, g ? 1'b0 : oh);
    if (flip) gapped_en_i = ~g;
    for (int i = 0; i < HIGH_DLY; i++) @(negedge clk_i);
    chk(g ? (oh ? "R6 no edge" : "R5 payload edge") : "R4 edge", clk_o, exp_clk);
    for (int i = HIGH_DLY + 1; i < SPACING; i++) begin
      @(negedge clk_i);
      chk("R2 hold", ser_o, b);
      chk(flip ? "R9 clk after flip" : "R10 clk steady", clk_o, exp_clk);
      chk(flip ? "R9 ind after flip" : "R7 ind hold", ohind_o, g ? 1'b0 : oh);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 ser", ser_o, 1'b0);
    chk("R1 clk", clk_o, 1'b0);
    chk("R1 ind", ohind_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int rep = 0; rep < 4; rep++)
      for (int idx = 0; idx < 8; idx++)
        send_bit(idx[2], idx[1], idx[0] ^ rep[0], 1'b0);
    // runs of overhead in gapped mode, then back to continuous
    for (int k = 0; k < 6; k++) send_bit(1'b1, k < 3, k[0], 1'b0);
    for (int k = 0; k < 6; k++) send_bit(1'b0, k >= 3, k[1], 1'b0);
    // mode flips mid-bit
    for (int idx = 0; idx < 8; idx++) send_bit(idx[2], idx[1], idx[0], 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule